// File: doc/BRIEF.md
# SPI register slave with deferred read

This block is an SPI target that gives a host access to an external register file. Every transfer uses a fixed 17-bit frame, sent most significant bit first: a direction bit, an 8-bit register address, then an 8-bit data field. SCK, select and MOSI are oversampled by the system clock through a synchroniser, so the whole block runs in one clock domain. The register file sits outside the block, behind a parallel port with separate write and read strobes.

A write frame updates the addressed register when select is released. A read needs two select windows. The first frame carries the read command and the address, and its data field is filler. That frame is decoded only when select is released. The register is then fetched, and its contents come back on MISO during the next frame, which the host clocks as a dummy transfer. A frame of the wrong length is dropped and flagged. A select-high gap shorter than a programmable number of system clocks is also flagged.

Top module: `spi_deferred_reg_slave`

## Requirements
- R1: A frame is shifted in on rising SCK edges, most significant bit first. Bit 16 is the direction (1 = read, 0 = write), bits 15..8 are the address and bits 7..0 are the data field.
- R2: After select is released on a frame of exactly 17 clocks with direction 0, `reg_wr_en` pulses for one cycle with `reg_addr` and `reg_wdata` taken from that frame.
- R3: After select is released on a frame of exactly 17 clocks with direction 1, `reg_rd_en` pulses for one cycle with the frame's address and no write happens. The data field of that frame is ignored.
- R4: The frame that follows a completed read command returns the 17-bit word {1, address, register data} on MISO, most significant bit first. The first bit is valid as soon as the output is enabled, before the first SCK edge. This holds whatever the following frame contains.
- R5: In any frame not preceded by a completed read command, MISO reads as all zeros.
- R6: On select release with a clock count other than 17, including a select held low across two frames, the frame is discarded: no write, no read fetch, and the next frame returns zeros. `frame_err` pulses for one cycle.
- R7: When select falls after a high period shorter than `GUARD_CYC` synchronised system cycles, `guard_err` pulses for one cycle. The frame is still processed. A high period of at least `GUARD_CYC` cycles raises no flag.
- R8: While the synchronised select is high, `miso_oe` is low and `miso` is 0.
- R9: During reset, `miso_oe`, `miso`, both register strobes and both error flags are low.
- R10: While the output is enabled, MISO changes only on a falling SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when not enabled |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register address for either strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, combinational from `reg_addr` |
| frame_err | output | 1 | One-cycle pulse: frame length was not 17 |
| guard_err | output | 1 | One-cycle pulse: select-high gap was too short |

## Verification
Plain write frames show that the address and data fields are placed correctly and that MISO stays zero when no read is pending. A read command followed by a read-command dummy, then by a write dummy, shows that the returned word belongs to the previous frame and that the dummy's own content is still acted on. A 10-clock frame and a 34-clock frame under one select separate discarded frames from valid ones, and show that no fetch happens when select is never released between frames. Gaps of 20 and 200 cycles against a 125-cycle limit bracket the guard threshold. A cycle-level reference model checks every output on every clock.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign level = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_reg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_active,
  input  logic   sel_start,
  input  logic   sel_end,
  input  logic   sck_rise,
  input  logic   mosi_bit,
  output frame_t frame,
  output logic   frame_ok,
  output logic   frame_bad
);
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (sel_start) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (sel_active && sck_rise) begin
      sh_d = {sh_q[FRAME_W-2:0], mosi_bit};
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign frame     = sh_q;
  assign frame_ok  = sel_end && (cnt_q == CNT_W'(FRAME_W));
  assign frame_bad = sel_end && (cnt_q != CNT_W'(FRAME_W));
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
  import spi_reg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_active,
  input  logic               sck_fall,
  input  logic               clear,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  output logic               out_bit
);
  logic [FRAME_W-1:0] tx_q, tx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)                         tx_d = load_word;
    else if (clear)                   tx_d = '0;
    else if (sel_active && sck_fall)  tx_d = {tx_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign out_bit = tx_q[FRAME_W-1];
endmodule

// File: rtl/spi_guard_timer.sv
module spi_guard_timer #(
  parameter int GUARD_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_idle,
  input  logic sel_start,
  output logic short_gap
);
  localparam int HW = $clog2(GUARD_CYC + 1);
  localparam logic [HW-1:0] LIMIT = HW'(GUARD_CYC);

  logic [HW-1:0] hi_q, hi_d;

  always_comb begin
    hi_d = hi_q;
    if (!sel_idle)          hi_d = '0;
    else if (hi_q != LIMIT) hi_d = hi_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= LIMIT;
    else        hi_q <= hi_d;
  end

  assign short_gap = sel_start && (hi_q < LIMIT);
endmodule

// File: rtl/spi_deferred_reg_slave.sv
module spi_deferred_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int GUARD_CYC   = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              frame_err,
  output logic              guard_err
);
  logic [2:0] pin_lvl;
  logic [1:0] edge_prev_q;
  logic       ss_lvl, sck_lvl, mosi_lvl;
  logic       sel_start, sel_end, sck_rise, sck_fall;
  frame_t     rx_frame;
  logic       frame_ok, frame_bad, short_gap, tx_bit;

  logic              wr_q, wr_d, rd_q, rd_d, ferr_q, ferr_d, gerr_q, gerr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ss_n, sck, mosi}), .level(pin_lvl)
  );

  assign ss_lvl   = pin_lvl[2];
  assign sck_lvl  = pin_lvl[1];
  assign mosi_lvl = pin_lvl[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev_q <= 2'b10;
    else        edge_prev_q <= {ss_lvl, sck_lvl};
  end

  assign sel_start = !ss_lvl &&  edge_prev_q[1];
  assign sel_end   =  ss_lvl && !edge_prev_q[1];
  assign sck_rise  =  sck_lvl && !edge_prev_q[0];
  assign sck_fall  = !sck_lvl &&  edge_prev_q[0];

  spi_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sel_active(!ss_lvl), .sel_start(sel_start),
    .sel_end(sel_end), .sck_rise(sck_rise), .mosi_bit(mosi_lvl),
    .frame(rx_frame), .frame_ok(frame_ok), .frame_bad(frame_bad)
  );

  spi_guard_timer #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .sel_idle(ss_lvl), .sel_start(sel_start),
    .short_gap(short_gap)
  );

  spi_tx_shifter u_tx (
    .clk(clk), .rst_n(rst_n), .sel_active(!ss_lvl), .sck_fall(sck_fall),
    .clear(sel_end), .load(rd_q), .load_word({1'b1, addr_q, reg_rdata}),
    .out_bit(tx_bit)
  );

  always_comb begin
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    ferr_d  = frame_bad;
    gerr_d  = short_gap;
    if (frame_ok) begin
      addr_d = rx_frame.addr;
      if (rx_frame.rd) begin
        rd_d = 1'b1;
      end else begin
        wr_d    = 1'b1;
        wdata_d = rx_frame.data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ferr_q  <= 1'b0;
      gerr_q  <= 1'b0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      ferr_q  <= ferr_d;
      gerr_q  <= gerr_d;
    end
  end

  assign miso_oe   = !ss_lvl;
  assign miso      = miso_oe & tx_bit;
  assign reg_wr_en = wr_q;
  assign reg_rd_en = rd_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign frame_err = ferr_q;
  assign guard_err = gerr_q;
endmodule

// File: rtl/spi_deferred_reg_slave_chk.sv
module spi_deferred_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic miso,
  input logic miso_oe,
  input logic reg_wr_en,
  input logic reg_rd_en,
  input logic frame_err,
  input logic guard_err,
  input logic sel_end,
  input logic sck_fall
);
  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  p_strobe_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en || frame_err) |-> $past(sel_end));

  p_rd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

  p_no_rd_with_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  p_err_excludes_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (!reg_wr_en && !reg_rd_en));

  p_guard_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    guard_err |-> $past(miso_oe));

  p_release_hides_miso_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_end |=> (!miso_oe && !miso));

  p_miso_moves_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$past(sck_fall)) |-> $stable(miso));
endmodule

bind spi_deferred_reg_slave spi_deferred_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .miso(miso), .miso_oe(miso_oe),
  .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .frame_err(frame_err),
  .guard_err(guard_err), .sel_end(sel_end), .sck_fall(sck_fall)
);

// File: tb/tb_spi_deferred_reg_slave.sv
module tb_spi_deferred_reg_slave;
  localparam int G    = 125;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, sck, ss_n, mosi;
  logic miso, miso_oe, reg_wr_en, reg_rd_en, frame_err, guard_err;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];

  int total = 0, bad = 0;
  int wr_seen = 0, rd_seen = 0, ferr_seen = 0, gerr_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_deferred_reg_slave #(.GUARD_CYC(G)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_err(frame_err), .guard_err(guard_err)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr_en) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Cycle-level reference model: two-flop input delay, edge tracking, integers.
  logic [2:0]  m0, m1, m2;
  logic [16:0] m_bits, m_resp;
  logic [7:0]  m_addr, m_wdata;
  int          m_cnt, m_hi;
  bit          m_wr, m_rd, m_ferr, m_gerr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m0 = 3'b100; m1 = 3'b100; m2 = 3'b100;
      m_cnt = 0; m_bits = '0; m_resp = '0; m_hi = G;
      m_wr = 0; m_rd = 0; m_ferr = 0; m_gerr = 0; m_addr = '0; m_wdata = '0;
    end else begin
      bit old_rd, s_now, s_prev, k_now, k_prev, d_now;
      old_rd = m_rd;
      s_now = m1[2]; s_prev = m2[2]; k_now = m1[1]; k_prev = m2[1]; d_now = m1[0];
      m_wr = 0; m_rd = 0; m_ferr = 0; m_gerr = 0;
      if (old_rd) m_resp = {1'b1, m_addr, mem[m_addr]};
      if (!s_now && s_prev) begin
        m_gerr = (m_hi < G); m_cnt = 0; m_bits = '0;
      end else if (!s_now && k_now && !k_prev) begin
        m_bits = {m_bits[15:0], d_now};
        if (m_cnt < 63) m_cnt++;
      end
      if (!s_now && !k_now && k_prev) m_resp = {m_resp[15:0], 1'b0};
      if (s_now && !s_prev) begin
        m_resp = '0;
        if (m_cnt == 17) begin
          m_addr = m_bits[15:8];
          if (m_bits[16]) m_rd = 1;
          else begin m_wr = 1; m_wdata = m_bits[7:0]; end
        end else m_ferr = 1;
      end
      if (s_now) m_hi = (m_hi >= G) ? G : m_hi + 1;
      else       m_hi = 0;
      m2 = m1; m1 = m0; m0 = {ss_n, sck, mosi};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_oe;
      e_oe = !m1[2];
      if (reg_wr_en) wr_seen++;
      if (reg_rd_en) rd_seen++;
      if (frame_err) ferr_seen++;
      if (guard_err) gerr_seen++;
      chk(miso_oe == e_oe, "R8 miso_oe", 32'(miso_oe), 32'(e_oe));
      chk(miso == (e_oe & m_resp[16]), "R4 R10 miso", 32'(miso), 32'(e_oe & m_resp[16]));
      chk(reg_wr_en == m_wr, "R2 write strobe", 32'(reg_wr_en), 32'(m_wr));
      chk(reg_rd_en == m_rd, "R3 read strobe", 32'(reg_rd_en), 32'(m_rd));
      chk(frame_err == m_ferr, "R6 frame_err", 32'(frame_err), 32'(m_ferr));
      chk(guard_err == m_gerr, "R7 guard_err", 32'(guard_err), 32'(m_gerr));
      if (m_wr || m_rd) chk(reg_addr == m_addr, "R1 address", 32'(reg_addr), 32'(m_addr));
      if (m_wr) chk(reg_wdata == m_wdata, "R2 wdata", 32'(reg_wdata), 32'(m_wdata));
    end
  end

  task automatic do_frame(input int n, input logic [33:0] w, output logic [33:0] rx);
    rx = '0;
    @(negedge clk) ss_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = w[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[32:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    ss_n = 1'b1;
    mosi = 1'b0;
  endtask

  task automatic gap(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [33:0] rx;
    int w0, r0, f0, g0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    rst_n = 1'b0; ss_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    repeat (3) @(negedge clk);
    chk({miso_oe, miso, reg_wr_en, reg_rd_en, frame_err, guard_err} == 6'b0,
        "R9 reset outputs", 32'({miso_oe, miso, reg_wr_en, reg_rd_en, frame_err, guard_err}), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    gap(200);

    do_frame(17, {17'b0, 1'b0, 8'h12, 8'hA5}, rx); gap(200);
    chk(mem[8'h12] == 8'hA5, "R2 write 0x12", 32'(mem[8'h12]), 32'hA5);
    chk(rx[16:0] == 17'h0, "R5 write frame miso", 32'(rx[16:0]), 32'h0);

    do_frame(17, {17'b0, 1'b0, 8'h80, 8'h3C}, rx); gap(200);
    chk(mem[8'h80] == 8'h3C, "R2 write 0x80", 32'(mem[8'h80]), 32'h3C);

    w0 = wr_seen; r0 = rd_seen;
    do_frame(17, {17'b0, 1'b1, 8'h12, 8'hFF}, rx); gap(200);
    chk(wr_seen == w0, "R3 read command writes nothing", 32'(wr_seen - w0), 32'h0);
    chk(rd_seen == r0 + 1, "R3 read fetch", 32'(rd_seen - r0), 32'h1);
    chk(mem[8'h12] == 8'hA5, "R3 filler ignored", 32'(mem[8'h12]), 32'hA5);

    do_frame(17, {17'b0, 1'b1, 8'h80, 8'hFF}, rx); gap(200);
    chk(rx[16:0] == {1'b1, 8'h12, 8'hA5}, "R1 R4 read-dummy return", 32'(rx[16:0]), 32'({1'b1, 8'h12, 8'hA5}));

    do_frame(17, {17'b0, 1'b0, 8'h40, 8'h77}, rx); gap(200);
    chk(rx[16:0] == {1'b1, 8'h80, 8'h3C}, "R4 write-dummy return", 32'(rx[16:0]), 32'({1'b1, 8'h80, 8'h3C}));
    chk(mem[8'h40] == 8'h77, "R2 dummy write lands", 32'(mem[8'h40]), 32'h77);

    do_frame(17, {17'b0, 1'b0, 8'h41, 8'h00}, rx); gap(200);
    chk(rx[16:0] == 17'h0, "R5 after return", 32'(rx[16:0]), 32'h0);

    w0 = wr_seen; f0 = ferr_seen;
    do_frame(10, {24'b0, 1'b0, 8'h12, 1'b0}, rx); gap(200);
    chk(ferr_seen == f0 + 1, "R6 short frame flagged", 32'(ferr_seen - f0), 32'h1);
    chk(wr_seen == w0 && mem[8'h12] == 8'hA5, "R6 short frame no write", 32'(mem[8'h12]), 32'hA5);

    r0 = rd_seen; f0 = ferr_seen;
    do_frame(34, {1'b1, 8'h40, 8'hFF, 1'b1, 8'h40, 8'hFF}, rx); gap(200);
    chk(ferr_seen == f0 + 1, "R6 merged frames flagged", 32'(ferr_seen - f0), 32'h1);
    chk(rd_seen == r0, "R6 merged frames no fetch", 32'(rd_seen - r0), 32'h0);
    do_frame(17, {17'b0, 1'b0, 8'h42, 8'h99}, rx); gap(200);
    chk(rx[16:0] == 17'h0, "R6 no return after merged frames", 32'(rx[16:0]), 32'h0);

    g0 = gerr_seen;
    do_frame(17, {17'b0, 1'b0, 8'h05, 8'h11}, rx); gap(20);
    do_frame(17, {17'b0, 1'b0, 8'h06, 8'h22}, rx); gap(200);
    chk(gerr_seen == g0 + 1, "R7 short gap flagged", 32'(gerr_seen - g0), 32'h1);
    chk(mem[8'h06] == 8'h22, "R7 frame after short gap processed", 32'(mem[8'h06]), 32'h22);
    g0 = gerr_seen;
    do_frame(17, {17'b0, 1'b0, 8'h07, 8'h33}, rx); gap(200);
    chk(gerr_seen == g0, "R7 long gap not flagged", 32'(gerr_seen - g0), 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule